// File: doc/BRIEF.md
# Control-Transfer Next-PC Resolver

This unit resolves the control-transfer instructions of a 32-bit base instruction encoding. It takes one instruction word with its address and the two source operands from a register-file read port. From these it produces the address of the next instruction, an optional register write-back, and an illegal flag. The supported instructions are the direct jump, the register-indirect jump, add-upper-immediate-to-PC and the six conditional branches. The block rebuilds the scrambled jump and branch immediates and sign-extends them to the data width. It compares the operands for branches and forms the return address for jumps.

The register-file read indices leave the block combinationally from the instruction word, and the operand values are expected back in the same cycle. Every result is captured into output registers on a cycle where `valid_i` is high. The results then appear one clock later together with `valid_o`. The data width `XLEN` may be 32 or 64.

Top module: `ctl_xfer_resolver`

## Requirements
- R1: Opcode 1101111 (direct jump): `npc_o` = `pc_i` + offset. The offset takes bit 20 from insn[31], bits 19:12 from insn[19:12], bit 11 from insn[20] and bits 10:1 from insn[30:21]. Bit 0 of the offset is zero, and the offset is sign-extended from bit 20. The write-back value is `pc_i` + 4 and the write-back index is insn[11:7].
- R2: Opcode 1100111 with insn[14:12] = 000 (indirect jump): `npc_o` = (rs1 + sign-extended insn[31:20]) with bit 0 cleared. The write-back value is `pc_i` + 4. Any other insn[14:12] with this opcode is illegal, following R6.
- R3: Opcode 0010111: the write-back value is `pc_i` + ({insn[31:12], 12'b0} sign-extended from bit 31), and `npc_o` = `pc_i` + 4.
- R4: Opcode 1100011 (branch): the offset takes bit 12 from insn[31], bit 11 from insn[7], bits 10:5 from insn[30:25] and bits 4:1 from insn[11:8]. Bit 0 is zero, and the offset is sign-extended from bit 12. A taken branch gives `npc_o` = `pc_i` + offset, and a not-taken branch gives `pc_i` + 4. A branch never writes back.
- R5: The branch condition follows insn[14:12]: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal.
- R6: A branch whose insn[14:12] is 010 or 011 sets `illegal_o`. It clears `wb_en_o` and gives `npc_o` = `pc_i`.
- R7: Any other opcode sets `illegal_o`, clears `wb_en_o` and gives `npc_o` = `pc_i`.
- R8: A write-back to index 0 is dropped, so `wb_en_o` stays low. An operand read from index 0 is zero whatever the read port returns.
- R9: `rs1_addr_o` = insn[19:15] and `rs2_addr_o` = insn[24:20], both combinational. The results and `valid_o` appear one clock after a cycle with `valid_i` high. With `valid_i` low, `valid_o` falls and the result outputs hold their values.
- R10: While `rst_ni` is low, all outputs except the read indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Instruction address |
| rs1_addr_o | output | 5 | First read-port index |
| rs2_addr_o | output | 5 | Second read-port index |
| rs1_data_i | input | XLEN | First read-port data |
| rs2_data_i | input | XLEN | Second read-port data |
| valid_o | output | 1 | Result valid |
| npc_o | output | XLEN | Next instruction address |
| wb_en_o | output | 1 | Write-back enable |
| wb_idx_o | output | 5 | Write-back register index |
| wb_data_o | output | XLEN | Write-back value |
| illegal_o | output | 1 | Instruction not handled |

## Verification
Jump offsets are tried with both signs and with isolated high bits, so that a misplaced immediate field shows up as a wrong target. Each branch condition is driven with equal operands, and with operand pairs whose signed and unsigned orders disagree (all ones against one). This separates the signed compares from the unsigned ones and the strict compares from the inclusive ones. Index 0 is used as a jump base, as a branch source and as a destination to exercise the zero-register rule. Reserved branch codes, a reserved indirect-jump code and a foreign opcode confirm that the illegal path blocks both write-back and PC advance.

// File: rtl/cxr_pkg.sv
package cxr_pkg;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  localparam logic [2:0] BC_EQ  = 3'b000;
  localparam logic [2:0] BC_NE  = 3'b001;
  localparam logic [2:0] BC_LT  = 3'b100;
  localparam logic [2:0] BC_GE  = 3'b101;
  localparam logic [2:0] BC_LTU = 3'b110;
  localparam logic [2:0] BC_GEU = 3'b111;

  typedef enum logic [2:0] {
    K_BAD, K_JAL, K_JALR, K_AUIPC, K_BR
  } kind_e;
endpackage

// File: rtl/cxr_decode.sv
module cxr_decode
  import cxr_pkg::*;
(
  input  logic [31:0] insn_i,
  output kind_e       kind_o
);
  logic [6:0] opc;
  logic [2:0] f3;
  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];

  always_comb begin
    unique case (opc)
      OPC_JAL:    kind_o = K_JAL;
      OPC_JALR:   kind_o = (f3 == 3'b000) ? K_JALR : K_BAD;
      OPC_AUIPC:  kind_o = K_AUIPC;
      OPC_BRANCH: kind_o = (f3[2:1] == 2'b01) ? K_BAD : K_BR;
      default:    kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/cxr_imm.sv
module cxr_imm #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     insn_i,
  output logic [XLEN-1:0] imm_j_o,
  output logic [XLEN-1:0] imm_i_o,
  output logic [XLEN-1:0] imm_b_o,
  output logic [XLEN-1:0] imm_u_o
);
  logic [20:0] j_raw;
  logic [11:0] i_raw;
  logic [12:0] b_raw;
  logic [31:0] u_raw;

  // scrambled fields back into offset order
  assign j_raw = {insn_i[31], insn_i[19:12], insn_i[20], insn_i[30:21], 1'b0};
  assign i_raw = insn_i[31:20];
  assign b_raw = {insn_i[31], insn_i[7], insn_i[30:25], insn_i[11:8], 1'b0};
  assign u_raw = {insn_i[31:12], 12'b0};

  assign imm_j_o = XLEN'($signed(j_raw));
  assign imm_i_o = XLEN'($signed(i_raw));
  assign imm_b_o = XLEN'($signed(b_raw));
  assign imm_u_o = XLEN'($signed(u_raw));
endmodule

// File: rtl/cxr_branch.sv
module cxr_branch
  import cxr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      cond_i,
  output logic            taken_o
);
  logic eq, lt_s, lt_u;
  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    unique case (cond_i)
      BC_EQ:   taken_o = eq;
      BC_NE:   taken_o = !eq;
      BC_LT:   taken_o = lt_s;
      BC_GE:   taken_o = !lt_s;
      BC_LTU:  taken_o = lt_u;
      BC_GEU:  taken_o = !lt_u;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctl_xfer_resolver.sv
module ctl_xfer_resolver
  import cxr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [4:0]      rs1_addr_o,
  output logic [4:0]      rs2_addr_o,
  input  logic [XLEN-1:0] rs1_data_i,
  input  logic [XLEN-1:0] rs2_data_i,
  output logic            valid_o,
  output logic [XLEN-1:0] npc_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            illegal_o
);
  localparam logic [XLEN-1:0] STEP     = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_MASK = {{(XLEN-1){1'b1}}, 1'b0};

  kind_e           kind;
  logic [XLEN-1:0] imm_j, imm_i, imm_b, imm_u;
  logic [XLEN-1:0] op_a, op_b, link;
  logic [4:0]      rd;
  logic            taken;

  logic [XLEN-1:0] npc_d, wdat_d;
  logic            wen_d, ill_d;

  assign rs1_addr_o = insn_i[19:15];
  assign rs2_addr_o = insn_i[24:20];
  assign rd         = insn_i[11:7];

  // index 0 reads as zero
  assign op_a = (rs1_addr_o == 5'd0) ? '0 : rs1_data_i;
  assign op_b = (rs2_addr_o == 5'd0) ? '0 : rs2_data_i;
  assign link = pc_i + STEP;

  cxr_decode u_dec (
    .insn_i (insn_i),
    .kind_o (kind)
  );

  cxr_imm #(.XLEN(XLEN)) u_imm (
    .insn_i  (insn_i),
    .imm_j_o (imm_j),
    .imm_i_o (imm_i),
    .imm_b_o (imm_b),
    .imm_u_o (imm_u)
  );

  cxr_branch #(.XLEN(XLEN)) u_br (
    .a_i     (op_a),
    .b_i     (op_b),
    .cond_i  (insn_i[14:12]),
    .taken_o (taken)
  );

  always_comb begin
    npc_d  = pc_i;
    wdat_d = '0;
    wen_d  = 1'b0;
    ill_d  = 1'b0;
    unique case (kind)
      K_JAL: begin
        npc_d  = pc_i + imm_j;
        wdat_d = link;
        wen_d  = 1'b1;
      end
      K_JALR: begin
        npc_d  = (op_a + imm_i) & LSB_MASK;
        wdat_d = link;
        wen_d  = 1'b1;
      end
      K_AUIPC: begin
        npc_d  = link;
        wdat_d = pc_i + imm_u;
        wen_d  = 1'b1;
      end
      K_BR: begin
        npc_d = pc_i + (taken ? imm_b : STEP);
      end
      default: begin
        ill_d = 1'b1;
      end
    endcase
    if (rd == 5'd0) wen_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      npc_o     <= '0;
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        npc_o     <= npc_d;
        wb_en_o   <= wen_d;
        wb_idx_o  <= rd;
        wb_data_o <= wdat_d;
        illegal_o <= ill_d;
      end
    end
  end

  assert_valid_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(npc_o) && $stable(wb_en_o)));
  assert_no_wb_x0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != 5'd0));
  assert_ill_no_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o);
  assert_jalr_lsb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == K_JALR) |=> (npc_o[0] == 1'b0));
  assert_link_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind == K_JAL || kind == K_JALR)) |=> (wb_data_o == $past(pc_i) + STEP));
  assert_br_no_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == K_BR) |=> (!wb_en_o && !illegal_o));
endmodule

// File: tb/sim_ctl_xfer_resolver.sv
module sim_ctl_xfer_resolver;
  localparam int XLEN = 32;
  localparam int NV   = 21;

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] npc;
    logic        wen;
    logic [4:0]  widx;
    logic [31:0] wdat;
    logic        ill;
  } vec_t;

  function automatic logic [31:0] enc_j(input logic [4:0] rd, input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jr(input logic [4:0] rd, input logic [4:0] rs,
                                         input logic [11:0] off, input logic [2:0] f3);
    return {off, rs, f3, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] enc_u(input logic [4:0] rd, input logic [19:0] hi);
    return {hi, rd, 7'b0010111};
  endfunction
  function automatic logic [31:0] enc_b(input logic [2:0] f3, input logic [4:0] r1,
                                        input logic [4:0] r2, input logic [12:0] off);
    return {off[12], off[10:5], r2, r1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  // insn, pc, rs1 data, rs2 data, npc, wen, widx, wdata, illegal
  localparam vec_t VEC [NV] = '{
    '{enc_j(5'd1, 21'h000800), 32'h1000, 32'h0, 32'h0, 32'h1800, 1'b1, 5'd1, 32'h1004, 1'b0},      // R1 bit11
    '{enc_j(5'd5, 21'h1FFFFC), 32'h2000, 32'h0, 32'h0, 32'h1FFC, 1'b1, 5'd5, 32'h2004, 1'b0},      // R1 negative
    '{enc_j(5'd0, 21'h0FF00E), 32'h0100, 32'h0, 32'h0, 32'hFF10E, 1'b0, 5'd0, 32'h0, 1'b0},        // R8 rd0
    '{enc_jr(5'd2, 5'd3, 12'hFFD, 3'b000), 32'h10, 32'h4000, 32'h0, 32'h3FFC, 1'b1, 5'd2, 32'h14, 1'b0}, // R2
    '{enc_jr(5'd1, 5'd0, 12'h7FF, 3'b000), 32'h20, 32'hDEAD0000, 32'h0, 32'h7FE, 1'b1, 5'd1, 32'h24, 1'b0}, // R8 base x0
    '{enc_jr(5'd1, 5'd3, 12'h010, 3'b001), 32'h30, 32'h4000, 32'h0, 32'h30, 1'b0, 5'd0, 32'h0, 1'b1},  // R2 bad f3
    '{enc_u(5'd7, 20'h80000), 32'h1234, 32'h0, 32'h0, 32'h1238, 1'b1, 5'd7, 32'h80001234, 1'b0},     // R3
    '{enc_b(3'b000, 5'd1, 5'd2, 13'h1FF8), 32'h100, 32'd5, 32'd5, 32'hF8, 1'b0, 5'd0, 32'h0, 1'b0},   // R5 eq taken
    '{enc_b(3'b001, 5'd1, 5'd2, 13'h0010), 32'h100, 32'd5, 32'd5, 32'h104, 1'b0, 5'd0, 32'h0, 1'b0},  // R5 ne not taken
    '{enc_b(3'b100, 5'd1, 5'd2, 13'h0800), 32'h1000, 32'hFFFFFFFF, 32'd1, 32'h1800, 1'b0, 5'd0, 32'h0, 1'b0}, // R5 lt
    '{enc_b(3'b110, 5'd1, 5'd2, 13'h0800), 32'h1000, 32'hFFFFFFFF, 32'd1, 32'h1004, 1'b0, 5'd0, 32'h0, 1'b0}, // R5 ltu
    '{enc_b(3'b101, 5'd1, 5'd2, 13'h0020), 32'h40, 32'hFFFFFFFF, 32'd1, 32'h44, 1'b0, 5'd0, 32'h0, 1'b0},     // R5 ge
    '{enc_b(3'b111, 5'd1, 5'd2, 13'h001E), 32'h40, 32'hFFFFFFFF, 32'd1, 32'h5E, 1'b0, 5'd0, 32'h0, 1'b0},     // R4 bits4:1
    '{enc_b(3'b101, 5'd1, 5'd2, 13'h0020), 32'h40, 32'd7, 32'd7, 32'h60, 1'b0, 5'd0, 32'h0, 1'b0},            // R5 ge equal
    '{enc_b(3'b000, 5'd0, 5'd5, 13'h0100), 32'h200, 32'd9, 32'd0, 32'h300, 1'b0, 5'd0, 32'h0, 1'b0},          // R8 rs1 x0
    '{enc_b(3'b010, 5'd1, 5'd2, 13'h0010), 32'h500, 32'd1, 32'd1, 32'h500, 1'b0, 5'd0, 32'h0, 1'b1},          // R6 010
    '{enc_b(3'b011, 5'd1, 5'd2, 13'h0010), 32'h600, 32'd1, 32'd2, 32'h600, 1'b0, 5'd0, 32'h0, 1'b1},          // R6 011
    '{32'h002081B3, 32'h700, 32'd1, 32'd2, 32'h700, 1'b0, 5'd0, 32'h0, 1'b1},                                 // R7
    '{enc_b(3'b110, 5'd1, 5'd2, 13'h1000), 32'h2000, 32'd1, 32'd2, 32'h1000, 1'b0, 5'd0, 32'h0, 1'b0},        // R4 bit12
    '{enc_u(5'd0, 20'h00001), 32'h0, 32'h0, 32'h0, 32'h4, 1'b0, 5'd0, 32'h0, 1'b0},                           // R8 auipc rd0
    '{enc_b(3'b111, 5'd1, 5'd2, 13'h0040), 32'h80, 32'd1, 32'hFFFFFFFF, 32'h84, 1'b0, 5'd0, 32'h0, 1'b0}      // R5 geu not taken
  };

  logic            clk, rst_ni, valid_i;
  logic [31:0]     insn_i;
  logic [XLEN-1:0] pc_i, rs1_data_i, rs2_data_i;
  logic [4:0]      rs1_addr_o, rs2_addr_o, wb_idx_o;
  logic            valid_o, wb_en_o, illegal_o;
  logic [XLEN-1:0] npc_o, wb_data_o;

  int n_run  = 0;
  int n_fail = 0;

  ctl_xfer_resolver #(.XLEN(XLEN)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .insn_i     (insn_i),
    .pc_i       (pc_i),
    .rs1_addr_o (rs1_addr_o),
    .rs2_addr_o (rs2_addr_o),
    .rs1_data_i (rs1_data_i),
    .rs2_data_i (rs2_data_i),
    .valid_o    (valid_o),
    .npc_o      (npc_o),
    .wb_en_o    (wb_en_o),
    .wb_idx_o   (wb_idx_o),
    .wb_data_o  (wb_data_o),
    .illegal_o  (illegal_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    insn_i     = v.insn;
    pc_i       = v.pc;
    rs1_data_i = v.a;
    rs2_data_i = v.b;
  endtask

  task automatic check_out(input string req, input vec_t v);
    chk(req, "valid", 64'(valid_o), 64'(1'b1));
    chk(req, "npc", 64'(npc_o), 64'(v.npc));
    chk(req, "wen", 64'(wb_en_o), 64'(v.wen));
    chk(req, "ill", 64'(illegal_o), 64'(v.ill));
    if (v.wen) begin
      chk(req, "widx", 64'(wb_idx_o), 64'(v.widx));
      chk(req, "wdat", 64'(wb_data_o), 64'(v.wdat));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0;
    insn_i = '0; pc_i = '0; rs1_data_i = '0; rs2_data_i = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "valid", 64'(valid_o), 64'd0);
    chk("R10", "npc", 64'(npc_o), 64'd0);
    chk("R10", "wen", 64'(wb_en_o), 64'd0);
    chk("R10", "widx", 64'(wb_idx_o), 64'd0);
    chk("R10", "wdat", 64'(wb_data_o), 64'd0);
    chk("R10", "ill", 64'(illegal_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      valid_i = 1'b1;
      #1;
      chk("R9", "rs1_addr", 64'(rs1_addr_o), 64'(VEC[i].insn[19:15]));
      chk("R9", "rs2_addr", 64'(rs2_addr_o), 64'(VEC[i].insn[24:20]));
      @(negedge clk);
      valid_i = 1'b0;
      check_out($sformatf("R1-5 vec%0d", i), VEC[i]);
    end

    // R9 hold: new inputs with valid low leave results untouched
    drive(VEC[0]);
    @(negedge clk);
    @(negedge clk);
    chk("R9", "valid low", 64'(valid_o), 64'd0);
    chk("R9", "npc hold", 64'(npc_o), 64'(VEC[NV-1].npc));
    chk("R9", "wen hold", 64'(wb_en_o), 64'd0);

    // R9 back-to-back
    drive(VEC[3]); valid_i = 1'b1;
    @(negedge clk);
    check_out("R9 b2b first", VEC[3]);
    drive(VEC[6]);
    @(negedge clk);
    check_out("R9 b2b second", VEC[6]);
    valid_i = 1'b0;

    // R10 asynchronous reset clears results mid-run
    #3 rst_ni = 1'b0;
    #2;
    chk("R10", "async npc", 64'(npc_o), 64'd0);
    chk("R10", "async wen", 64'(wb_en_o), 64'd0);
    chk("R10", "async wdat", 64'(wb_data_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule